// File: doc/BRIEF.md
# Bidirectional Parallel I/O Port with Peripheral Pin Override

This block is a 16-pin general purpose I/O port. Each pin has a direction bit, an output latch bit and a read path from the pin. Software reaches three registers over a simple register bus. The direction register sets which pins the port drives. The latch register holds the values the port drives onto its output pins. The port address gives the live pin levels on a read and loads the latch on a write. The latch and port addresses therefore read back different data whenever a pin is not at its latched value.

An on-chip peripheral can take ownership of individual pins. A peripheral owns a pin only when it is both enabled on that pin and actively driving it. On an owned pin the peripheral's data and drive replace the port's output driver, and the pin level can still be read through the port address. On a pin where a peripheral is enabled but not driving, the port keeps control. Pin inputs pass through a two-stage synchronizer before they reach the read path.

Top module: `gpio_port`

## Requirements
- R1: When no peripheral owns a pin, a direction bit of 0 sets that pin's `pinOe` to 1, and a direction bit of 1 sets it to 0. `pinOut` carries the latch bit for every pin that no peripheral owns.
- R2: After reset the direction register reads all ones, the latch reads all zeros and `pinOe` is all zeros.
- R3: Address 0 is the direction register. A write loads it on the accepting clock edge and a read returns its contents.
- R4: A read of address 2 returns the output latch contents and not the pin levels.
- R5: A write to address 1 (port) or to address 2 (latch) loads the output latch on the clock edge that accepts the write.
- R6: A read of address 1 returns the synchronized pin levels, not the latch.
- R7: A change on `pinIn` that is set up before clock edge k appears on a port read after edge k+1. After edge k alone, the read still shows the old value.
- R8: A pin is owned when `perEn` and `perDrive` are both 1 for it. An owned pin has `pinOe` = 1 and `pinOut` = `perData`, whatever its direction and latch bits are. Its level still reads through address 1.
- R9: A pin with `perEn` = 1 and `perDrive` = 0 behaves exactly as in R1.
- R10: Address 3 reads as zero, and a write to it changes neither the direction register nor the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 2 | Register address: 0 direction, 1 port, 2 latch, 3 unused |
| busWrEn | input | 1 | Write strobe, accepted on the rising clock edge |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Combinational read data for `busAddr` |
| pinIn | input | 16 | Pin levels from the pads |
| pinOut | output | 16 | Value for each pad driver |
| pinOe | output | 16 | Output enable for each pad driver, 1 = drive |
| perEn | input | 16 | Peripheral enabled on the pin |
| perDrive | input | 16 | Peripheral actively driving the pin |
| perData | input | 16 | Peripheral output value for the pin |

## Verification
The hardest case to reach is a mixed ownership pattern. Here owned pins, enabled-but-idle pins and plain port pins sit side by side, and their direction bits are set to the opposite of the values ownership would need. The stimulus sets a non-trivial latch and direction pattern first, then applies peripheral masks that split the word into all three classes. It then flips the direction register under the same masks. This shows that ownership ignores direction while idle peripherals do not. The pin level is then changed while pins are owned, so that the port read path can be checked under override and the two-clock synchronizer latency can be checked edge by edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_DIR  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PORT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_LAT  = 2'd2;

  typedef enum logic [1:0] {
    RD_DIR  = 2'd0,
    RD_PORT = 2'd1,
    RD_LAT  = 2'd2,
    RD_NONE = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   wrDir;
    logic   wrLat;
    rdSel_e rdSel;
  } ctlStrobe_t;

endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output ctlStrobe_t        ctl
);

  always_comb begin
    ctl.wrDir = 1'b0;
    ctl.wrLat = 1'b0;
    ctl.rdSel = RD_NONE;
    unique case (busAddr)
      ADDR_DIR: begin
        ctl.wrDir = busWrEn;
        ctl.rdSel = RD_DIR;
      end
      ADDR_PORT: begin
        ctl.wrLat = busWrEn;
        ctl.rdSel = RD_PORT;
      end
      ADDR_LAT: begin
        ctl.wrLat = busWrEn;
        ctl.rdSel = RD_LAT;
      end
      default: begin
        ctl.wrDir = 1'b0;
        ctl.wrLat = 1'b0;
        ctl.rdSel = RD_NONE;
      end
    endcase
  end

  // R10: the unused address never raises a write strobe
  p_no_strobe_unused_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 2'd3) |-> !(ctl.wrDir || ctl.wrLat));

  // R3/R5: at most one register is written per cycle
  p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.wrDir, ctl.wrLat}));

endmodule

// File: rtl/gpio_dp.sv
module gpio_dp
  import gpio_pkg::*;
#(
  parameter int NUM_PINS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          ctl,
  input  logic [NUM_PINS-1:0] busWrData,
  output logic [NUM_PINS-1:0] busRdData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  input  logic [NUM_PINS-1:0] perEn,
  input  logic [NUM_PINS-1:0] perDrive,
  input  logic [NUM_PINS-1:0] perData,
  output logic [NUM_PINS-1:0] dirQ,
  output logic [NUM_PINS-1:0] latQ
);

  localparam logic [NUM_PINS-1:0] DIR_RESET = {NUM_PINS{1'b1}};
  localparam logic [NUM_PINS-1:0] LAT_RESET = {NUM_PINS{1'b0}};
  localparam int                  LAST_STG  = SYNC_STAGES - 1;

  logic [NUM_PINS-1:0] syncQ [SYNC_STAGES];
  logic [NUM_PINS-1:0] pinLevel;

  // direction register, 1 = input
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          dirQ <= DIR_RESET;
    else if (ctl.wrDir) dirQ <= busWrData;
  end

  // output latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          latQ <= LAT_RESET;
    else if (ctl.wrLat) latQ <= busWrData;
  end

  // input synchronizer chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
    end else begin
      syncQ[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
    end
  end

  assign pinLevel = syncQ[LAST_STG];

  // per-pin pad multiplexer: peripheral ownership wins over the port driver
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pad
    logic owned;
    assign owned    = perEn[i] & perDrive[i];
    assign pinOe[i] = owned | ~dirQ[i];
    assign pinOut[i] = owned ? perData[i] : latQ[i];
  end

  always_comb begin
    unique case (ctl.rdSel)
      RD_DIR:  busRdData = dirQ;
      RD_PORT: busRdData = pinLevel;
      RD_LAT:  busRdData = latQ;
      default: busRdData = '0;
    endcase
  end

  // R3: a direction write lands on the accepting edge
  p_dir_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrDir |=> (dirQ == $past(busWrData)));

  // R5: without a latch strobe the latch holds
  p_lat_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.wrLat |=> $stable(latQ));

  // R1/R9: a pin no peripheral owns is driven only if its direction bit is 0
  p_input_float_r1: assert property (@(posedge clk) disable iff (!rstN)
    ((pinOe & ~(perEn & perDrive) & dirQ) == '0));

  // R8: every owned pin is driven
  p_owned_driven_r8: assert property (@(posedge clk) disable iff (!rstN)
    (((perEn & perDrive) & ~pinOe) == '0));

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int NUM_PINS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrEn,
  input  logic [NUM_PINS-1:0] busWrData,
  output logic [NUM_PINS-1:0] busRdData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  input  logic [NUM_PINS-1:0] perEn,
  input  logic [NUM_PINS-1:0] perDrive,
  input  logic [NUM_PINS-1:0] perData
);

  ctlStrobe_t          ctl;
  logic [NUM_PINS-1:0] dirQ;
  logic [NUM_PINS-1:0] latQ;

  gpio_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .ctl     (ctl)
  );

  gpio_dp #(
    .NUM_PINS    (NUM_PINS),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .pinIn     (pinIn),
    .pinOut    (pinOut),
    .pinOe     (pinOe),
    .perEn     (perEn),
    .perDrive  (perDrive),
    .perData   (perData),
    .dirQ      (dirQ),
    .latQ      (latQ)
  );

  // R5: a bus write to the port address loads the latch
  p_port_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_PORT) |=> (latQ == $past(busWrData)));

  // R10: a write to the unused address leaves both registers unchanged
  p_unused_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 2'd3) |=> ($stable(latQ) && $stable(dirQ)));

  // R10: the unused address reads zero
  p_unused_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 2'd3) |-> (busRdData == '0));

endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;

  localparam int W = 16;

  typedef struct {
    int          what;   // 0 read data, 1 pinOut, 2 pinOe
    logic [W-1:0] exp;
    string       tag;
  } item_t;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [1:0]   busAddr = 2'd0;
  logic         busWrEn = 1'b0;
  logic [W-1:0] busWrData = '0;
  logic [W-1:0] busRdData;
  logic [W-1:0] pinIn = '0;
  logic [W-1:0] pinOut;
  logic [W-1:0] pinOe;
  logic [W-1:0] perEn = '0;
  logic [W-1:0] perDrive = '0;
  logic [W-1:0] perData = '0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  item_t sb[$];

  always #2 clk = ~clk;

  gpio_port u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .perEn(perEn), .perDrive(perDrive),
    .perData(perData)
  );

  // monitor: compares queued expectations 1 ns after the falling edge
  always @(negedge clk) begin
    #1;
    while (sb.size() > 0) begin
      item_t it;
      logic [W-1:0] act;
      it = sb.pop_front();
      act = (it.what == 0) ? busRdData : (it.what == 1) ? pinOut : pinOe;
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic busWrite(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic expRead(input logic [1:0] a, input logic [W-1:0] e, input string tag);
    item_t it;
    busAddr = a;
    it.what = 0; it.exp = e; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic expPad(input int what, input logic [W-1:0] e, input string tag);
    item_t it;
    it.what = what; it.exp = e; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
  endtask

  function automatic logic [W-1:0] padOut(input logic [W-1:0] lat);
    logic [W-1:0] own;
    own = perEn & perDrive;
    return (own & perData) | (~own & lat);
  endfunction

  function automatic logic [W-1:0] padOe(input logic [W-1:0] dir);
    return (perEn & perDrive) | ~dir;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R2 reset state
    expRead(2'd0, 16'hFFFF, "R2 dir reset");
    expRead(2'd2, 16'h0000, "R2 latch reset");
    expPad(2, 16'h0000, "R2 oe reset");

    // R3 direction, R4 latch readback, R1 drive
    busWrite(2'd0, 16'hFF00);
    expRead(2'd0, 16'hFF00, "R3 dir readback");
    busWrite(2'd2, 16'hA5C3);
    expRead(2'd2, 16'hA5C3, "R4 latch readback");
    expPad(2, 16'h00FF, "R1 oe from dir");
    expPad(1, 16'hA5C3, "R1 out from latch");

    // R5 write through port address
    busWrite(2'd1, 16'h1234);
    expRead(2'd2, 16'h1234, "R5 port write loads latch");

    // R6/R7 pin read path and latency
    pinIn = 16'h5A5A;
    @(negedge clk);
    expRead(2'd1, 16'h0000, "R7 one edge still old");
    expRead(2'd1, 16'h5A5A, "R6 port reads pins");
    expRead(2'd2, 16'h1234, "R4 latch differs from port");

    // R8/R9 mixed ownership, outputs everywhere
    busWrite(2'd0, 16'h0000);
    perEn = 16'hF0F0; perDrive = 16'h30FF; perData = 16'hA0C0;
    expPad(2, padOe(16'h0000), "R9 oe mixed dir0");
    expPad(1, padOut(16'h1234), "R8 out mixed dir0");
    busWrite(2'd0, 16'hFFFF);
    expPad(2, padOe(16'hFFFF), "R8 oe owned ignores dir");
    expPad(1, padOut(16'h1234), "R8 out owned ignores latch");
    busWrite(2'd0, 16'h0F0F);
    expPad(2, padOe(16'h0F0F), "R9 idle peripheral follows dir");

    // R8 owned pin still readable
    pinIn = 16'h30F0;
    @(negedge clk);
    @(negedge clk);
    expRead(2'd1, 16'h30F0, "R8 owned pin readable");

    // R10 unused address
    expRead(2'd3, 16'h0000, "R10 unused reads zero");
    busWrite(2'd3, 16'hDEAD);
    expRead(2'd0, 16'h0F0F, "R10 dir untouched");
    expRead(2'd2, 16'h1234, "R10 latch untouched");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin : watchdog
    int n;
    n = 0;
    while (!done && n < 5000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule